// File: doc/BRIEF.md
# Codec Command and Response Ring Engine

This block feeds an audio codec link from two circular rings in system memory. Software fills a command ring with 32-bit command words and advances a write pointer. The engine then reads one entry at a time and splits it into codec address, node id and payload. It offers the result on a valid/ready command output and waits for that handshake before it fetches the next entry. Codec replies arrive on a valid/ready response input. Each reply is written as a two-word entry into a response ring. The second word of the entry records whether the reply was unsolicited and which codec sent it.

Command fetching is paced by a response counter. Once the number of stored replies reaches a programmed threshold, fetching halts and a response interrupt flag is raised. Fetching resumes when software clears that flag. A separate immediate-command path lets software issue a single command without either ring. It has priority over ring traffic, and its reply is captured in a status register instead of memory. Software reaches the block through a small write-only register port. The pointers, the flag and the immediate status are visible on output ports.

Top module: `cre_ring_engine`

## Requirements
- R1: A forwarded command word is split as codec address = bits 31..28, node id = bits 26..20, payload = bits 19..0; bit 27 is the indirect flag.
- R2: A command with bit 27 set, or one whose codec address has a clear bit in `codec_present_i`, is never presented on the command output; fetching continues with the next entry.
- R3: The command read pointer is 8 bits, starts at 0, and advances by one per fetch modulo 256; the entry is read from word address command base + (read pointer + 1).
- R4: No command is fetched while the run bit is clear, while the read pointer equals the command write pointer, or while the response count equals the threshold.
- R5: At most one command is outstanding: the output fields stay stable while `cmd_valid_o` is high and `cmd_ready_i` is low, and no further fetch starts before the handshake.
- R6: A response with response DMA enabled is written to word address response base + 2 × ((write pointer + 1) mod 256), word 0 = response data, word 1 = unsolicited flag in bit 4 and codec address in bits 3..0. After the write, the response write pointer and the response count each advance by one.
- R7: With response DMA disabled (control register 6 bit 1 clear), a ring response is accepted and discarded: no memory write, no pointer change.
- R8: After a response is stored, the interrupt flag `rsp_irq_o` is set if the interrupt enable (register 6 bit 0) is on and either the count has reached the threshold or the command ring is empty; it is never set while the enable is off.
- R9: Writing 1 to bit 0 of register 7 while the flag is set clears the flag, resets the response count to zero and lets fetching resume.
- R10: Writing 1 to bit 0 of register 9 makes the immediate command (register 8) busy. It is sent before any pending ring entry. A reply arriving while busy is not written to memory: it clears busy (status bit 0), sets valid (status bit 1), records the codec in status bits 7..4 and the data on `imm_rsp_o`. Writing register 9 with bit 0 clear drops busy, and bit 1 set clears valid.
- R11: Writing register 4 with bit 15 set returns the response write pointer to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register index (0 cmd base, 1 cmd write ptr, 2 run, 3 rsp base, 4 rsp ptr reset, 5 threshold, 6 rsp control, 7 rsp status, 8 immediate word, 9 immediate status) |
| reg_wdata_i | input | 32 | Register write data |
| codec_present_i | input | 16 | One bit per codec address that exists |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | AW | Word address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid one cycle after a read request |
| cmd_valid_o | output | 1 | Decoded command available |
| cmd_ready_i | input | 1 | Codec side accepts the command |
| cmd_codec_o | output | 4 | Codec address |
| cmd_node_o | output | 7 | Node id |
| cmd_payload_o | output | 20 | Command payload |
| rsp_valid_i | input | 1 | Codec response available |
| rsp_ready_o | output | 1 | Engine accepts a response |
| rsp_data_i | input | 32 | Response data |
| rsp_unsol_i | input | 1 | Response was unsolicited |
| rsp_codec_i | input | 4 | Responding codec address |
| cmd_rp_o | output | 8 | Command read pointer |
| rsp_wp_o | output | 8 | Response write pointer |
| rsp_irq_o | output | 1 | Response interrupt flag |
| imm_sts_o | output | 8 | Immediate status: bit 0 busy, bit 1 valid, bits 7..4 codec |
| imm_rsp_o | output | 32 | Immediate response data |

## Verification
The bench goes after the throttle. It sets a threshold of two with three entries queued and expects exactly two commands, then the third only after the flag is cleared. An engine that compared the count late or reset it on the wrong event would leak the third command or stall forever. It places an indirect-flagged entry and one for an absent codec between good ones. A wrong decode would forward them or lose the entries after them. The bench also raises the immediate busy bit while a ring command is held at the output and checks that the immediate word goes out before the next ring entry, with its reply kept out of the response ring. It further checks the unsolicited marker and codec field in the second response word. It checks that responses are dropped with DMA off, that the interrupt stays down with its enable off, and that the pointer reset makes the next entry land at slot one.

// File: rtl/cre_pkg.sv
package cre_pkg;
  localparam int CAD_W  = 4;
  localparam int NID_W  = 7;
  localparam int PAY_W  = 20;
  localparam int WORD_W = 32;
  localparam int PTR_W  = 8;
  localparam int NCODEC = 2 ** CAD_W;
  localparam int RIDX_W = 4;

  // MSB first: codec, indirect flag, node, payload
  typedef struct packed {
    logic [CAD_W-1:0] cad;
    logic             ind;
    logic [NID_W-1:0] nid;
    logic [PAY_W-1:0] pay;
  } cmd_word_t;

  typedef enum logic [1:0] {F_IDLE, F_WAIT, F_OUT} fetch_st_e;
  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI}    store_st_e;

  localparam logic [RIDX_W-1:0] REG_CMD_BASE = 4'd0;
  localparam logic [RIDX_W-1:0] REG_CMD_WP   = 4'd1;
  localparam logic [RIDX_W-1:0] REG_CMD_CTL  = 4'd2;
  localparam logic [RIDX_W-1:0] REG_RSP_BASE = 4'd3;
  localparam logic [RIDX_W-1:0] REG_RSP_WP   = 4'd4;
  localparam logic [RIDX_W-1:0] REG_THRESH   = 4'd5;
  localparam logic [RIDX_W-1:0] REG_RSP_CTL  = 4'd6;
  localparam logic [RIDX_W-1:0] REG_RSP_STS  = 4'd7;
  localparam logic [RIDX_W-1:0] REG_IMM_CMD  = 4'd8;
  localparam logic [RIDX_W-1:0] REG_IMM_STS  = 4'd9;

  localparam int WP_RST_BIT = 15;
endpackage

// File: rtl/cre_cmd_fetch.sv
module cre_cmd_fetch
  import cre_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 run_i,
  input  logic [AW-1:0]        base_i,
  input  logic [PTR_W-1:0]     wp_i,
  input  logic [PTR_W-1:0]     count_i,
  input  logic [PTR_W-1:0]     thresh_i,
  input  logic                 store_idle_i,
  input  logic                 imm_pend_i,
  input  logic [WORD_W-1:0]    imm_word_i,
  input  logic [NCODEC-1:0]    present_i,
  output logic                 rd_req_o,
  output logic [AW-1:0]        rd_addr_o,
  input  logic [WORD_W-1:0]    rd_data_i,
  output logic                 imm_take_o,
  output logic [PTR_W-1:0]     rp_o,
  output logic                 cmd_valid_o,
  input  logic                 cmd_ready_i,
  output cmd_word_t            cmd_o
);
  fetch_st_e          st_q;
  logic [PTR_W-1:0]   rp_q, rp_nxt;
  cmd_word_t          cmd_q, imm_w, rd_w;
  logic               imm_ok, rd_ok, ring_go;

  assign imm_w   = cmd_word_t'(imm_word_i);
  assign rd_w    = cmd_word_t'(rd_data_i);
  assign imm_ok  = !imm_w.ind && present_i[imm_w.cad];
  assign rd_ok   = !rd_w.ind && present_i[rd_w.cad];
  assign rp_nxt  = rp_q + 1'b1;
  assign ring_go = run_i && (rp_q != wp_i) && (count_i != thresh_i) && store_idle_i;

  assign imm_take_o  = (st_q == F_IDLE) && imm_pend_i;
  assign rd_req_o    = (st_q == F_IDLE) && !imm_pend_i && ring_go;
  assign rd_addr_o   = base_i + AW'(rp_nxt);
  assign rp_o        = rp_q;
  assign cmd_valid_o = (st_q == F_OUT);
  assign cmd_o       = cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= F_IDLE;
      rp_q  <= '0;
      cmd_q <= '0;
    end else begin
      unique case (st_q)
        F_IDLE: begin
          if (imm_take_o) begin
            if (imm_ok) begin
              cmd_q <= imm_w;
              st_q  <= F_OUT;
            end
          end else if (rd_req_o) begin
            rp_q <= rp_nxt;
            st_q <= F_WAIT;
          end
        end
        F_WAIT: begin
          if (rd_ok) begin
            cmd_q <= rd_w;
            st_q  <= F_OUT;
          end else begin
            st_q <= F_IDLE;
          end
        end
        F_OUT: if (cmd_ready_i) st_q <= F_IDLE;
        default: st_q <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cre_rsp_store.sv
module cre_rsp_store
  import cre_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [AW-1:0]        base_i,
  input  logic                 dma_en_i,
  input  logic                 irq_en_i,
  input  logic [PTR_W-1:0]     thresh_i,
  input  logic                 ring_empty_i,
  input  logic                 wp_rst_i,
  input  logic                 irq_clr_i,
  input  logic                 imm_set_i,
  input  logic                 imm_clr_i,
  input  logic                 imm_vclr_i,
  input  logic                 imm_take_i,
  input  logic                 rsp_valid_i,
  output logic                 rsp_ready_o,
  input  logic [WORD_W-1:0]    rsp_data_i,
  input  logic                 rsp_unsol_i,
  input  logic [CAD_W-1:0]     rsp_codec_i,
  output logic                 wr_req_o,
  output logic [AW-1:0]        wr_addr_o,
  output logic [WORD_W-1:0]    wr_data_o,
  output logic                 idle_o,
  output logic [PTR_W-1:0]     wp_o,
  output logic [PTR_W-1:0]     count_o,
  output logic                 irq_o,
  output logic                 imm_busy_o,
  output logic                 imm_pend_o,
  output logic                 imm_valid_o,
  output logic [CAD_W-1:0]     imm_cad_o,
  output logic [WORD_W-1:0]    imm_rsp_o
);
  store_st_e           st_q;
  logic [PTR_W-1:0]    wp_q, cnt_q, cnt_nxt, slot_idx;
  logic                irq_q, unsol_q, busy_q, sent_q, ivalid_q;
  logic [CAD_W-1:0]    cad_q, icad_q;
  logic [WORD_W-1:0]   rsp_q, irsp_q;
  logic [AW-1:0]       slot_addr;

  assign cnt_nxt   = cnt_q + 1'b1;
  assign slot_idx  = wp_q + 1'b1;
  assign slot_addr = base_i + (AW'(slot_idx) << 1);

  assign rsp_ready_o = (st_q == S_IDLE);
  assign idle_o      = (st_q == S_IDLE);
  assign wr_req_o    = (st_q == S_LO) || (st_q == S_HI);
  assign wr_addr_o   = (st_q == S_HI) ? slot_addr + AW'(1) : slot_addr;
  // second word: unsolicited flag at bit 4, codec below it
  assign wr_data_o   = (st_q == S_HI) ? WORD_W'({unsol_q, cad_q}) : rsp_q;

  assign wp_o        = wp_q;
  assign count_o     = cnt_q;
  assign irq_o       = irq_q;
  assign imm_busy_o  = busy_q;
  assign imm_pend_o  = busy_q && !sent_q;
  assign imm_valid_o = ivalid_q;
  assign imm_cad_o   = icad_q;
  assign imm_rsp_o   = irsp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      wp_q     <= '0;
      cnt_q    <= '0;
      irq_q    <= 1'b0;
      rsp_q    <= '0;
      unsol_q  <= 1'b0;
      cad_q    <= '0;
      busy_q   <= 1'b0;
      sent_q   <= 1'b0;
      ivalid_q <= 1'b0;
      icad_q   <= '0;
      irsp_q   <= '0;
    end else begin
      if (imm_take_i) sent_q <= 1'b1;
      if (imm_set_i) begin
        busy_q <= 1'b1;
        sent_q <= 1'b0;
      end
      if (imm_clr_i)  busy_q   <= 1'b0;
      if (imm_vclr_i) ivalid_q <= 1'b0;
      if (irq_clr_i && irq_q) begin
        irq_q <= 1'b0;
        cnt_q <= '0;
      end
      unique case (st_q)
        S_IDLE: begin
          if (rsp_valid_i) begin
            if (busy_q) begin
              irsp_q   <= rsp_data_i;
              icad_q   <= rsp_codec_i;
              busy_q   <= 1'b0;
              ivalid_q <= 1'b1;
            end else if (dma_en_i) begin
              rsp_q   <= rsp_data_i;
              unsol_q <= rsp_unsol_i;
              cad_q   <= rsp_codec_i;
              st_q    <= S_LO;
            end
          end
        end
        S_LO: st_q <= S_HI;
        S_HI: begin
          st_q  <= S_IDLE;
          wp_q  <= slot_idx;
          cnt_q <= cnt_nxt;
          if (irq_en_i && ((cnt_nxt == thresh_i) || ring_empty_i)) irq_q <= 1'b1;
        end
        default: st_q <= S_IDLE;
      endcase
      if (wp_rst_i) wp_q <= '0;
    end
  end
endmodule

// File: rtl/cre_ring_engine.sv
module cre_ring_engine
  import cre_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic [RIDX_W-1:0]    reg_addr_i,
  input  logic [WORD_W-1:0]    reg_wdata_i,
  input  logic [NCODEC-1:0]    codec_present_i,
  output logic                 mem_req_o,
  output logic                 mem_we_o,
  output logic [AW-1:0]        mem_addr_o,
  output logic [WORD_W-1:0]    mem_wdata_o,
  input  logic [WORD_W-1:0]    mem_rdata_i,
  output logic                 cmd_valid_o,
  input  logic                 cmd_ready_i,
  output logic [CAD_W-1:0]     cmd_codec_o,
  output logic [NID_W-1:0]     cmd_node_o,
  output logic [PAY_W-1:0]     cmd_payload_o,
  input  logic                 rsp_valid_i,
  output logic                 rsp_ready_o,
  input  logic [WORD_W-1:0]    rsp_data_i,
  input  logic                 rsp_unsol_i,
  input  logic [CAD_W-1:0]     rsp_codec_i,
  output logic [PTR_W-1:0]     cmd_rp_o,
  output logic [PTR_W-1:0]     rsp_wp_o,
  output logic                 rsp_irq_o,
  output logic [7:0]           imm_sts_o,
  output logic [WORD_W-1:0]    imm_rsp_o
);
  logic [AW-1:0]      cmd_base_q, rsp_base_q;
  logic [PTR_W-1:0]   cmd_wp_q, thresh_q, count;
  logic               run_q, irq_en_q, dma_en_q;
  logic [WORD_W-1:0]  imm_cmd_q;
  logic               wp_rst, irq_clr, imm_set, imm_clr, imm_vclr;
  logic               rd_req, wr_req, store_idle, imm_take, imm_pend;
  logic               imm_busy, imm_valid;
  logic [CAD_W-1:0]   imm_cad;
  logic [AW-1:0]      rd_addr, wr_addr;
  logic [WORD_W-1:0]  wr_data;
  cmd_word_t          cmd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_base_q <= '0;
      rsp_base_q <= '0;
      cmd_wp_q   <= '0;
      thresh_q   <= '0;
      run_q      <= 1'b0;
      irq_en_q   <= 1'b0;
      dma_en_q   <= 1'b0;
      imm_cmd_q  <= '0;
    end else if (reg_we_i) begin
      unique case (reg_addr_i)
        REG_CMD_BASE: cmd_base_q <= reg_wdata_i[AW-1:0];
        REG_CMD_WP:   cmd_wp_q   <= reg_wdata_i[PTR_W-1:0];
        REG_CMD_CTL:  run_q      <= reg_wdata_i[0];
        REG_RSP_BASE: rsp_base_q <= reg_wdata_i[AW-1:0];
        REG_THRESH:   thresh_q   <= reg_wdata_i[PTR_W-1:0];
        REG_RSP_CTL: begin
          irq_en_q <= reg_wdata_i[0];
          dma_en_q <= reg_wdata_i[1];
        end
        REG_IMM_CMD:  imm_cmd_q  <= reg_wdata_i;
        default: ;
      endcase
    end
  end

  assign wp_rst   = reg_we_i && (reg_addr_i == REG_RSP_WP)  && reg_wdata_i[WP_RST_BIT];
  assign irq_clr  = reg_we_i && (reg_addr_i == REG_RSP_STS) && reg_wdata_i[0];
  assign imm_set  = reg_we_i && (reg_addr_i == REG_IMM_STS) && reg_wdata_i[0];
  assign imm_clr  = reg_we_i && (reg_addr_i == REG_IMM_STS) && !reg_wdata_i[0];
  assign imm_vclr = reg_we_i && (reg_addr_i == REG_IMM_STS) && reg_wdata_i[1];

  cre_cmd_fetch #(.AW(AW)) i_fetch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run_q),
    .base_i       (cmd_base_q),
    .wp_i         (cmd_wp_q),
    .count_i      (count),
    .thresh_i     (thresh_q),
    .store_idle_i (store_idle),
    .imm_pend_i   (imm_pend),
    .imm_word_i   (imm_cmd_q),
    .present_i    (codec_present_i),
    .rd_req_o     (rd_req),
    .rd_addr_o    (rd_addr),
    .rd_data_i    (mem_rdata_i),
    .imm_take_o   (imm_take),
    .rp_o         (cmd_rp_o),
    .cmd_valid_o  (cmd_valid_o),
    .cmd_ready_i  (cmd_ready_i),
    .cmd_o        (cmd)
  );

  cre_rsp_store #(.AW(AW)) i_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .base_i       (rsp_base_q),
    .dma_en_i     (dma_en_q),
    .irq_en_i     (irq_en_q),
    .thresh_i     (thresh_q),
    .ring_empty_i (cmd_rp_o == cmd_wp_q),
    .wp_rst_i     (wp_rst),
    .irq_clr_i    (irq_clr),
    .imm_set_i    (imm_set),
    .imm_clr_i    (imm_clr),
    .imm_vclr_i   (imm_vclr),
    .imm_take_i   (imm_take),
    .rsp_valid_i  (rsp_valid_i),
    .rsp_ready_o  (rsp_ready_o),
    .rsp_data_i   (rsp_data_i),
    .rsp_unsol_i  (rsp_unsol_i),
    .rsp_codec_i  (rsp_codec_i),
    .wr_req_o     (wr_req),
    .wr_addr_o    (wr_addr),
    .wr_data_o    (wr_data),
    .idle_o       (store_idle),
    .wp_o         (rsp_wp_o),
    .count_o      (count),
    .irq_o        (rsp_irq_o),
    .imm_busy_o   (imm_busy),
    .imm_pend_o   (imm_pend),
    .imm_valid_o  (imm_valid),
    .imm_cad_o    (imm_cad),
    .imm_rsp_o    (imm_rsp_o)
  );

  // fetch reads only while the store side is idle, so the port never collides
  assign mem_req_o   = rd_req || wr_req;
  assign mem_we_o    = wr_req;
  assign mem_addr_o  = wr_req ? wr_addr : rd_addr;
  assign mem_wdata_o = wr_data;

  assign cmd_codec_o   = cmd.cad;
  assign cmd_node_o    = cmd.nid;
  assign cmd_payload_o = cmd.pay;
  assign imm_sts_o     = {imm_cad, 2'b00, imm_valid, imm_busy};
endmodule

// File: rtl/cre_checker.sv
module cre_checker
  import cre_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cmd_valid_o,
  input logic               cmd_ready_i,
  input logic [CAD_W-1:0]   cmd_codec_o,
  input logic [NID_W-1:0]   cmd_node_o,
  input logic [PAY_W-1:0]   cmd_payload_o,
  input logic [NCODEC-1:0]  codec_present_i,
  input logic [PTR_W-1:0]   cmd_rp_o,
  input logic [PTR_W-1:0]   cmd_wp,
  input logic [PTR_W-1:0]   rsp_wp_o,
  input logic [PTR_W-1:0]   count,
  input logic [PTR_W-1:0]   thresh,
  input logic               run,
  input logic               irq_en,
  input logic               rsp_irq_o
);
  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_codec_o)
      && $stable(cmd_node_o) && $stable(cmd_payload_o));

  assert_present_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> codec_present_i[cmd_codec_o]);

  assert_rp_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_rp_o != $past(cmd_rp_o)) |-> (cmd_rp_o == $past(cmd_rp_o) + 8'd1));

  assert_fetch_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run || (cmd_rp_o == cmd_wp) || (count == thresh)) |=> $stable(cmd_rp_o));

  assert_wp_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_wp_o != $past(rsp_wp_o)) |-> (rsp_wp_o == $past(rsp_wp_o) + 8'd1) || (rsp_wp_o == '0));

  assert_irq_en_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rsp_irq_o) |-> $past(irq_en));
endmodule

bind cre_ring_engine cre_checker i_cre_checker (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .cmd_valid_o     (cmd_valid_o),
  .cmd_ready_i     (cmd_ready_i),
  .cmd_codec_o     (cmd_codec_o),
  .cmd_node_o      (cmd_node_o),
  .cmd_payload_o   (cmd_payload_o),
  .codec_present_i (codec_present_i),
  .cmd_rp_o        (cmd_rp_o),
  .cmd_wp          (cmd_wp_q),
  .rsp_wp_o        (rsp_wp_o),
  .count           (count),
  .thresh          (thresh_q),
  .run             (run_q),
  .irq_en          (irq_en_q),
  .rsp_irq_o       (rsp_irq_o)
);

// File: tb/test_cre_ring_engine.sv
module test_cre_ring_engine;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam logic [15:0] CB = 16'h0100;
  localparam logic [15:0] RB = 16'h0200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [15:0] present = 16'h0005;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0;
  logic cmd_valid, cmd_ready = 1'b0;
  logic [3:0] cmd_codec;
  logic [6:0] cmd_node;
  logic [19:0] cmd_payload;
  logic rsp_valid = 1'b0, rsp_ready, rsp_unsol = 1'b0;
  logic [31:0] rsp_data = '0;
  logic [3:0] rsp_codec = '0;
  logic [7:0] cmd_rp, rsp_wp, imm_sts;
  logic rsp_irq;
  logic [31:0] imm_rsp;

  logic [31:0] mem [0:1023];
  logic [31:0] exp_q [$];
  int n_chk = 0, n_fail = 0, codec_delay = 2;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cre_ring_engine #(.AW(AW)) i_cre_ring_engine (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .codec_present_i(present), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready),
    .cmd_codec_o(cmd_codec), .cmd_node_o(cmd_node), .cmd_payload_o(cmd_payload),
    .rsp_valid_i(rsp_valid), .rsp_ready_o(rsp_ready), .rsp_data_i(rsp_data),
    .rsp_unsol_i(rsp_unsol), .rsp_codec_i(rsp_codec), .cmd_rp_o(cmd_rp),
    .rsp_wp_o(rsp_wp), .rsp_irq_o(rsp_irq), .imm_sts_o(imm_sts), .imm_rsp_o(imm_rsp)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[9:0]];
    end
  end

  function automatic logic [31:0] mk(input int cad, input int ind, input int nid, input int pay);
    return {cad[3:0], ind[0], nid[6:0], pay[19:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic send_rsp(input logic [31:0] d, input bit u, input logic [3:0] c);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_data = d; rsp_unsol = u; rsp_codec = c;
    while (!rsp_ready) @(negedge clk);
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // codec model and scoreboard monitor: reply first, then accept and compare
  initial begin
    forever begin
      @(negedge clk);
      if (cmd_valid) begin
        logic [31:0] w;
        w = {cmd_codec, 1'b0, cmd_node, cmd_payload};
        repeat (codec_delay) @(negedge clk);
        if (cmd_node != 7'h7F) begin
          rsp_valid = 1'b1; rsp_data = ~w; rsp_unsol = 1'b0; rsp_codec = cmd_codec;
          while (!rsp_ready) @(negedge clk);
          @(negedge clk);
          rsp_valid = 1'b0;
        end
        repeat (4) @(negedge clk);
        if (exp_q.size() == 0) chk(0, "R2 unexpected command", w, 32'h0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          // R1 field split, R5 held until accept
          chk({cmd_codec, 1'b0, cmd_node, cmd_payload} == e, "R1/R5 command fields", w, e);
        end
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'hDEAD_0000 | i;
    idle(3);
    chk(cmd_valid == 0 && cmd_rp == 0 && rsp_wp == 0 && rsp_irq == 0 && imm_sts == 0,
        "reset state", {cmd_rp, rsp_wp, imm_sts, 7'b0, rsp_irq}, 32'h0);
    rst_n = 1'b1;
    idle(2);

    // phase 1: decode, reject, drop, store (R1 R2 R3 R6 R8)
    mem[CB+1] = mk(0, 0, 5, 20'h12345);
    mem[CB+2] = mk(2, 0, 17, 20'hABCDE);
    mem[CB+3] = mk(3, 0, 1, 1);
    mem[CB+4] = mk(0, 1, 2, 2);
    mem[CB+5] = mk(2, 0, 34, 20'h00055);
    exp_q.push_back(mem[CB+1]); exp_q.push_back(mem[CB+2]); exp_q.push_back(mem[CB+5]);
    wr(0, CB); wr(3, RB); wr(5, 8); wr(6, 3); wr(1, 5); wr(2, 1);
    idle(150);
    chk(exp_q.size() == 0, "R2 forwarded set", exp_q.size(), 0);
    chk(cmd_rp == 5, "R3 read pointer", cmd_rp, 5);
    chk(rsp_wp == 3, "R6 write pointer", rsp_wp, 3);
    chk(mem[RB+2] == ~mk(0, 0, 5, 20'h12345), "R6 slot1 data", mem[RB+2], ~mk(0, 0, 5, 20'h12345));
    chk(mem[RB+3] == 32'h0, "R6 slot1 tag", mem[RB+3], 0);
    chk(mem[RB+7] == 32'h2, "R6 slot3 tag", mem[RB+7], 2);
    chk(rsp_irq == 1, "R8 irq on empty ring", rsp_irq, 1);
    wr(7, 1);
    idle(2);
    chk(rsp_irq == 0, "R9 irq cleared", rsp_irq, 0);

    // phase 2: threshold throttle (R4 R8 R9)
    mem[CB+6] = mk(0, 0, 6, 6); mem[CB+7] = mk(0, 0, 7, 7); mem[CB+8] = mk(0, 0, 8, 8);
    exp_q.push_back(mem[CB+6]); exp_q.push_back(mem[CB+7]);
    wr(5, 2); wr(1, 8);
    idle(120);
    chk(cmd_rp == 7 && !cmd_valid, "R4 halt at threshold", cmd_rp, 7);
    chk(rsp_irq == 1, "R8 irq at threshold", rsp_irq, 1);
    exp_q.push_back(mem[CB+8]);
    wr(7, 1);
    idle(60);
    chk(cmd_rp == 8 && exp_q.size() == 0, "R9 fetch resumes", cmd_rp, 8);
    wr(7, 1);

    // phase 3: irq enable off (R8)
    wr(6, 2);
    mem[CB+9] = mk(2, 0, 9, 9);
    exp_q.push_back(mem[CB+9]);
    wr(1, 9);
    idle(60);
    chk(rsp_wp == 7 && rsp_irq == 0, "R8 no irq when disabled", {rsp_wp, 7'b0, rsp_irq}, {8'd7, 8'd0});
    wr(6, 3);

    // phase 4: unsolicited tag (R6)
    send_rsp(32'hCAFE_0001, 1'b1, 4'd2);
    idle(5);
    chk(mem[RB+16] == 32'hCAFE_0001, "R6 unsol data", mem[RB+16], 32'hCAFE_0001);
    chk(mem[RB+17] == 32'h12, "R6 unsol tag bit4", mem[RB+17], 32'h12);
    chk(rsp_irq == 1, "R8 threshold via unsolicited", rsp_irq, 1);
    wr(7, 1);

    // phase 5: DMA disabled (R7)
    wr(6, 1);
    send_rsp(32'h1111_2222, 1'b0, 4'd0);
    idle(5);
    chk(rsp_wp == 8, "R7 pointer unchanged", rsp_wp, 8);
    chk(mem[RB+18] == (32'hDEAD_0000 | (RB+18)), "R7 no write", mem[RB+18], 32'hDEAD_0000 | (RB+18));
    wr(6, 3);

    // phase 6: write pointer reset (R11)
    wr(4, 32'h8000);
    idle(1);
    chk(rsp_wp == 0, "R11 pointer reset", rsp_wp, 0);
    send_rsp(32'h3333_4444, 1'b1, 4'd0);
    idle(5);
    chk(mem[RB+2] == 32'h3333_4444 && rsp_wp == 1, "R11 next slot one", mem[RB+2], 32'h3333_4444);
    wr(7, 1);

    // phase 7: immediate priority (R10)
    codec_delay = 30;
    mem[CB+10] = mk(2, 0, 127, 1);
    mem[CB+11] = mk(0, 0, 3, 7);
    exp_q.push_back(mem[CB+10]);
    exp_q.push_back(mk(2, 0, 16, 20'h0BEEF));
    exp_q.push_back(mem[CB+11]);
    wr(1, 11);
    while (!cmd_valid) @(negedge clk);
    wr(8, mk(2, 0, 16, 20'h0BEEF));
    wr(9, 1);
    idle(200);
    chk(exp_q.size() == 0, "R10 order", exp_q.size(), 0);
    chk(imm_sts == 8'h22, "R10 status", imm_sts, 8'h22);
    chk(imm_rsp == ~mk(2, 0, 16, 20'h0BEEF), "R10 reply data", imm_rsp, ~mk(2, 0, 16, 20'h0BEEF));
    chk(rsp_wp == 2 && mem[RB+4] == ~mk(0, 0, 3, 7), "R10 reply kept off ring", rsp_wp, 2);
    wr(9, 2);
    idle(1);
    chk(imm_sts == 8'h20, "R10 valid cleared", imm_sts, 8'h20);
    wr(7, 1);
    codec_delay = 2;

    // phase 8: run bit gate (R4)
    wr(2, 0);
    mem[CB+12] = mk(0, 0, 4, 4);
    wr(1, 12);
    idle(40);
    chk(cmd_rp == 11 && !cmd_valid, "R4 run clear", cmd_rp, 11);
    exp_q.push_back(mem[CB+12]);
    wr(2, 1);
    idle(60);
    chk(cmd_rp == 12 && exp_q.size() == 0, "R4 run set", cmd_rp, 12);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule